// File: doc/BRIEF.md
# LVDS PHY Power-Up Sequencer

This block walks one or two LVDS transmitter PHYs from reset to a transmitting state and back again. It drives each PHY's control enables in a fixed order, one enable per clock cycle. After the PLL enable it waits for the PLL to report lock. The lock input is sampled only at a fixed interval of microsecond ticks. If lock never arrives within a bounded number of samples, the block raises a timeout flag for that PHY and carries on with the sequence anyway. In dual-link operation the secondary PHY is brought fully up, lock wait included, before the primary PHY is touched. On shutdown the primary PHY is taken down first and the secondary second.

A start pulse begins bring-up and captures the link mode. A single-cycle done pulse reports that every PHY in use is up. A stop request in any active state ends the sequence and runs the shutdown order. Stop works during bring-up as an abort, and during normal running. Divider value calculation and the analog PLL are handled outside this block.

The states are IDLE, UP (one enable per cycle, indexed by a step counter), LOCK (timed lock poll), RUN, and the shutdown states DN_CLK, DN_PLL and DN_RST. The transitions are:
- IDLE to UP on start.
- UP to LOCK after the last enable.
- LOCK to UP for the primary, once the secondary has finished.
- LOCK to RUN once the primary has finished.
- Any of UP, LOCK or RUN to DN_CLK on stop.
- DN_CLK to DN_PLL, then DN_PLL to DN_RST.
- DN_RST to DN_CLK of the secondary in dual-link mode.
- DN_RST to IDLE when the last PHY is down.

Top module: `lvds_phy_seq`

## Requirements
- R1: After reset both control words are zero, and both the done output and the timeout flags are low.
- R2: Each PHY has a 10-bit control word. Bit 0 is the combined digital and divider reset release. Bit 1 is power-ok. Bit 2 is the current-mode lane enable. Bit 3 is the voltage-mode and bias lane enable. Bit 4 is the digital lane enable. Bit 5 is the bias enable. Bit 6 is the DP, LS and bit clock-output enable. Bit 7 is the test and PLL output divider enable. Bit 8 is TX mode. Bit 9 is PLL enable. Bring-up sets the bits in order from bit 0 to bit 9, one per clock. k cycles after the sequence reaches a PHY, its word equals 2^k-1.
- R3: In single-link mode (dual_link low at start) only the primary PHY is sequenced, and the secondary word stays zero.
- R4: In dual-link mode the secondary PHY completes its enables and its lock wait before the primary word leaves zero. No done pulse is produced when the secondary finishes.
- R5: Lock is sampled only on every POLL_TICKS-th tick counted while waiting. Lock seen between samples, or during cycles with no tick, has no effect. The sequence advances at the first sample that sees lock.
- R6: If MAX_POLLS samples all miss lock, the PHY's timeout flag is set (bit 0 for the primary, bit 1 for the secondary) and the sequence continues as if locked. Both flags clear at the next start.
- R7: done is high for exactly one cycle, on the cycle after the primary PHY leaves its lock wait.
- R8: Shutdown of a PHY takes three cycles. The first clears bit 6, the next clears bit 9, and the next clears the whole word. The primary PHY is shut down first, then the secondary if dual-link, and then the block is idle.
- R9: Stop during bring-up aborts it, and no further enable is set on the abort cycle. Shutdown of all PHYs in use follows. Stop while idle has no effect.
- R10: Start while the block is busy has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin bring-up (sampled in idle) |
| stop | input | 1 | Shut down or abort |
| dual_link | input | 1 | Link mode captured at start: 1 selects both PHYs |
| pll_lock | input | 2 | PLL lock status, bit 0 primary, bit 1 secondary |
| tick_us | input | 1 | Microsecond tick, one cycle wide |
| ctl_pri | output | 10 | Primary PHY control word |
| ctl_sec | output | 10 | Secondary PHY control word |
| done | output | 1 | One-cycle pulse when all PHYs in use are up |
| lock_timeout | output | 2 | Sticky lock timeout flags per PHY |

## Verification
The bench steps through every enable of every PHY and compares each word with 2^k-1. A design that set enables out of order, or two at a time, fails at the first differing cycle. During the lock wait the bench raises lock on every non-sample cycle and, in one run, during a stretch with no ticks. A poller that sampled lock continuously, or counted cycles rather than ticks, would advance too early. Timeout runs on each PHY check that the flag lands on the right PHY and that the sequence still finishes. Aborts in the middle of the enables and during the lock wait check that no extra enable is set, and that the shutdown order (primary first, then clocks, PLL, reset) is kept even for PHYs that were only partly up.

// File: rtl/lvds_seq_pkg.sv
package lvds_seq_pkg;
    localparam int CTL_W   = 10;
    localparam int NUM_PHY = 2;

    // Control word bit positions, in bring-up order
    localparam int B_RST  = 0;
    localparam int B_PWR  = 1;
    localparam int B_CM   = 2;
    localparam int B_VMB  = 3;
    localparam int B_DIG  = 4;
    localparam int B_BIAS = 5;
    localparam int B_CLK  = 6;
    localparam int B_DIV  = 7;
    localparam int B_TX   = 8;
    localparam int B_PLL  = 9;

    typedef enum logic [2:0] {
        S_IDLE, S_UP, S_LOCK, S_RUN, S_DN_CLK, S_DN_PLL, S_DN_RST
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_HOLD, OP_SET, OP_CLR_CLK, OP_CLR_PLL, OP_CLR_ALL
    } ctl_op_t;
endpackage

// File: rtl/lvds_seq_timer.sv
module lvds_seq_timer #(
    parameter int POLL_TICKS = 1000,
    parameter int MAX_POLLS  = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic poll,
    output logic last
);
    localparam int PW = $clog2(POLL_TICKS + 1);
    localparam int NW = $clog2(MAX_POLLS + 1);

    logic [PW-1:0] tick_cnt;
    logic [NW-1:0] poll_cnt;

    assign poll = tick && (tick_cnt == PW'(POLL_TICKS - 1));
    assign last = (poll_cnt == NW'(MAX_POLLS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tick_cnt <= '0;
            poll_cnt <= '0;
        end else if (tick) begin
            if (poll) begin
                tick_cnt <= '0;
                poll_cnt <= poll_cnt + NW'(1);
            end else begin
                tick_cnt <= tick_cnt + PW'(1);
            end
        end
    end

    // R5
    tick_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tick_cnt) || $past(clr));

    // R6
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= NW'(MAX_POLLS));
endmodule

// File: rtl/lvds_seq_phy_ctl.sv
module lvds_seq_phy_ctl
    import lvds_seq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  ctl_op_t                  op,
    input  logic [$clog2(CTL_W)-1:0] idx,
    output logic [CTL_W-1:0]         ctl
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            unique case (op)
                OP_SET:     ctl[idx]   <= 1'b1;
                OP_CLR_CLK: ctl[B_CLK] <= 1'b0;
                OP_CLR_PLL: ctl[B_PLL] <= 1'b0;
                OP_CLR_ALL: ctl        <= '0;
                default:    ctl        <= ctl;
            endcase
        end
    end

    // R2
    pll_after_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[B_PLL] |-> ctl[B_TX]);

    // R2
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctl) <= $countones($past(ctl)) + 1);

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[B_RST] |-> (ctl == '0));
endmodule

// File: rtl/lvds_phy_seq.sv
module lvds_phy_seq
    import lvds_seq_pkg::*;
#(
    parameter int POLL_TICKS = 1000,
    parameter int MAX_POLLS  = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             dual_link,
    input  logic [1:0]       pll_lock,
    input  logic             tick_us,
    output logic [CTL_W-1:0] ctl_pri,
    output logic [CTL_W-1:0] ctl_sec,
    output logic             done,
    output logic [1:0]       lock_timeout
);
    localparam int SW = $clog2(CTL_W);

    seq_state_t    state_q, state_d;
    logic [SW-1:0] step_q, step_d;
    logic          cur_q, cur_d;
    logic          dual_q;
    logic          poll, last, lock_sel, advance;
    ctl_op_t       op_cur;
    logic [CTL_W-1:0] ctl_all [NUM_PHY];

    lvds_seq_timer #(.POLL_TICKS(POLL_TICKS), .MAX_POLLS(MAX_POLLS)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q != S_LOCK),
        .tick (tick_us),
        .poll (poll),
        .last (last)
    );

    assign lock_sel = pll_lock[cur_q];
    assign advance  = poll && (lock_sel || last);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        cur_d   = cur_q;
        unique case (state_q)
            S_IDLE: if (start) begin
                state_d = S_UP;
                step_d  = '0;
                cur_d   = dual_link;
            end
            S_UP: if (stop) begin
                state_d = S_DN_CLK;
                cur_d   = 1'b0;
            end else if (step_q == SW'(CTL_W - 1)) begin
                state_d = S_LOCK;
            end else begin
                step_d = step_q + SW'(1);
            end
            S_LOCK: if (stop) begin
                state_d = S_DN_CLK;
                cur_d   = 1'b0;
            end else if (advance) begin
                if (cur_q) begin
                    state_d = S_UP;
                    step_d  = '0;
                    cur_d   = 1'b0;
                end else begin
                    state_d = S_RUN;
                end
            end
            S_RUN: if (stop) begin
                state_d = S_DN_CLK;
                cur_d   = 1'b0;
            end
            S_DN_CLK: state_d = S_DN_PLL;
            S_DN_PLL: state_d = S_DN_RST;
            S_DN_RST: if (dual_q && !cur_q) begin
                state_d = S_DN_CLK;
                cur_d   = 1'b1;
            end else begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            cur_q   <= 1'b0;
            dual_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            cur_q   <= cur_d;
            if (state_q == S_IDLE && start) dual_q <= dual_link;
        end
    end

    // Registered status outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            lock_timeout <= '0;
        end else begin
            done <= (state_q == S_LOCK) && !stop && advance && !cur_q;
            if (state_q == S_IDLE && start)
                lock_timeout <= '0;
            else if (state_q == S_LOCK && !stop && poll && last && !lock_sel)
                lock_timeout[cur_q] <= 1'b1;
        end
    end

    // Operation applied to the PHY under the pointer
    always_comb begin
        unique case (state_q)
            S_UP:     op_cur = stop ? OP_HOLD : OP_SET;
            S_DN_CLK: op_cur = OP_CLR_CLK;
            S_DN_PLL: op_cur = OP_CLR_PLL;
            S_DN_RST: op_cur = OP_CLR_ALL;
            default:  op_cur = OP_HOLD;
        endcase
    end

    for (genvar g = 0; g < NUM_PHY; g++) begin : g_phy
        ctl_op_t op_g;
        assign op_g = (cur_q == 1'(g)) ? op_cur : OP_HOLD;
        lvds_seq_phy_ctl u_ctl (
            .clk  (clk),
            .rst_n(rst_n),
            .op   (op_g),
            .idx  (step_q),
            .ctl  (ctl_all[g])
        );
    end

    assign ctl_pri = ctl_all[0];
    assign ctl_sec = ctl_all[1];

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ctl_pri[B_PLL] && (!dual_q || ctl_sec[B_PLL]));

    // R4
    sec_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_pri[B_RST]) && dual_q) |-> ctl_sec[B_PLL]);

    // R3
    single_sec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && !dual_q) |-> (ctl_sec == '0));

    // R8
    pri_down_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_sec[B_RST]) |-> (ctl_pri == '0));

    // R6
    timeout_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_timeout[0]) |-> $past(state_q) == S_LOCK);
endmodule

// File: tb/lvds_phy_seq_tb.sv
module lvds_phy_seq_tb;
    localparam int POLL = 3;
    localparam int MAXP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic       dual_link = 1'b0;
    logic       tick_us = 1'b1;
    logic [1:0] pll_lock = 2'b00;
    logic [9:0] ctl_pri, ctl_sec;
    logic       done;
    logic [1:0] lock_timeout;
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lvds_phy_seq #(.POLL_TICKS(POLL), .MAX_POLLS(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .dual_link(dual_link), .pll_lock(pll_lock), .tick_us(tick_us),
        .ctl_pri(ctl_pri), .ctl_sec(ctl_sec), .done(done),
        .lock_timeout(lock_timeout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] word(input int idx);
        return (idx != 0) ? ctl_sec : ctl_pri;
    endfunction

    task automatic start_seq(input logic dl);
        start = 1'b1; dual_link = dl;
        @(negedge clk);
        start = 1'b0;
        chk("R6 flags cleared at start", 32'(lock_timeout), 0);
    endtask

    task automatic up_phy(input int idx, input logic [9:0] other, input string tag);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R2 one enable per cycle in order", 32'(word(idx)), (32'd1 << k) - 1);
            chk(tag, 32'(word(1 - idx)), 32'(other));
        end
    endtask

    task automatic lock_phase(input int idx, input int lockp, input bit gap);
        if (gap) begin
            tick_us = 1'b0; pll_lock[idx] = 1'b1;
            for (int g = 0; g < 6; g++) begin
                @(negedge clk);
                chk("R5 no sample without ticks", 32'(word(idx)), 32'h3FF);
                chk("R5 no done without ticks", 32'(done), 0);
            end
            tick_us = 1'b1;
        end
        for (int p = 1; p <= MAXP; p++) begin
            for (int c = 1; c <= POLL; c++) begin
                bit pe;
                pe = (c == POLL);
                pll_lock[idx] = pe ? (p >= lockp) : (p < lockp);
                @(negedge clk);
                if (pe && (p >= lockp || p == MAXP)) begin
                    chk("R6 timeout flag", 32'(lock_timeout[idx]), 32'(lockp > MAXP));
                    if (idx == 0) chk("R7 done after primary lock", 32'(done), 1);
                    else          chk("R4 no done after secondary", 32'(done), 0);
                    pll_lock[idx] = 1'b0;
                    return;
                end
                chk("R5 lock ignored between samples", 32'(word(idx)), 32'h3FF);
                chk("R5 no done while waiting", 32'(done), 0);
            end
        end
    endtask

    task automatic hold_busy(input logic [9:0] sec_exp);
        start = 1'b1; dual_link = ~dual_link;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R10 start ignored (primary)", 32'(ctl_pri), 32'h3FF);
            chk("R10 start ignored (secondary)", 32'(ctl_sec), 32'(sec_exp));
            chk("R10 no done", 32'(done), 0);
        end
    endtask

    task automatic shut(input bit dl, input logic [9:0] p0, input logic [9:0] s0, input string tag);
        logic [9:0] pe, se;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk({tag, " no change on stop cycle"}, 32'({ctl_sec, ctl_pri}), 32'({s0, p0}));
        pe = p0; se = s0;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            pe = (s == 0) ? (pe & ~10'h040) : (s == 1) ? (pe & ~10'h200) : 10'h000;
            chk("R8 primary shutdown step", 32'(ctl_pri), 32'(pe));
            chk("R8 secondary waits", 32'(ctl_sec), 32'(se));
            chk("R7 no done in shutdown", 32'(done), 0);
        end
        if (dl) begin
            for (int s = 0; s < 3; s++) begin
                @(negedge clk);
                se = (s == 0) ? (se & ~10'h040) : (s == 1) ? (se & ~10'h200) : 10'h000;
                chk("R8 secondary shutdown step", 32'(ctl_sec), 32'(se));
                chk("R8 primary stays down", 32'(ctl_pri), 0);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset words", 32'({ctl_sec, ctl_pri}), 0);
        chk("R1 reset done", 32'(done), 0);
        chk("R1 reset flags", 32'(lock_timeout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        @(negedge clk);
        chk("R9 stop while idle", 32'({ctl_sec, ctl_pri}), 0);

        // Single link, lock at first sample
        start_seq(1'b0);
        up_phy(0, 10'h000, "R3 secondary untouched");
        lock_phase(0, 1, 1'b0);
        @(negedge clk);
        chk("R7 done one cycle", 32'(done), 0);
        hold_busy(10'h000);
        shut(1'b0, 10'h3FF, 10'h000, "R8");

        // Dual link, secondary locks at sample 2, tick gap on primary
        start_seq(1'b1);
        up_phy(1, 10'h000, "R4 primary waits for secondary");
        lock_phase(1, 2, 1'b0);
        chk("R4 primary still zero after secondary lock", 32'(ctl_pri), 0);
        up_phy(0, 10'h3FF, "R4 secondary held up");
        lock_phase(0, 3, 1'b1);
        @(negedge clk);
        chk("R7 done one cycle dual", 32'(done), 0);
        hold_busy(10'h3FF);
        shut(1'b1, 10'h3FF, 10'h3FF, "R8");

        // Single link timeout
        start_seq(1'b0);
        up_phy(0, 10'h000, "R3 secondary untouched");
        lock_phase(0, MAXP + 1, 1'b0);
        @(negedge clk);
        chk("R6 primary flag held", 32'(lock_timeout), 32'h1);
        shut(1'b0, 10'h3FF, 10'h000, "R8");

        // Dual link, secondary timeout, primary locks
        start_seq(1'b1);
        up_phy(1, 10'h000, "R4 primary waits for secondary");
        lock_phase(1, MAXP + 1, 1'b0);
        up_phy(0, 10'h3FF, "R4 secondary held up");
        lock_phase(0, 1, 1'b0);
        @(negedge clk);
        chk("R6 only secondary flag", 32'(lock_timeout), 32'h2);
        shut(1'b1, 10'h3FF, 10'h3FF, "R8");

        // Abort in the middle of secondary enables
        start_seq(1'b1);
        repeat (5) @(negedge clk);
        chk("R9 partial secondary word", 32'(ctl_sec), 32'h01F);
        shut(1'b1, 10'h000, 10'h01F, "R9");

        // Abort during primary lock wait
        start_seq(1'b0);
        up_phy(0, 10'h000, "R3 secondary untouched");
        pll_lock = 2'b00;
        repeat (2) @(negedge clk);
        shut(1'b0, 10'h3FF, 10'h000, "R9");
        chk("R9 idle after abort", 32'({ctl_sec, ctl_pri}), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule